// File: doc/BRIEF.md
# Comparison Specification Branch Unit

This unit sits in the decode stage of a five-stage in-order pipeline. It splits a conditional branch into two instructions. A spec-write instruction stores a 16-bit comparison descriptor in a small local file. The descriptor names two general-purpose registers, or one register and an 8-bit constant. A later compare-and-branch instruction selects a descriptor by index and supplies a relational operator. Early in decode the unit reads the descriptor. The register numbers in it then drive the two read addresses of the general-purpose file within the same cycle. The unit forms the two operands and latches them with the operator into the decode-to-execute register. In execute, a signed comparator produces the branch-taken flag.

Spec writes are committed to the file one cycle after they are presented. A compare-and-branch in the cycle directly after a spec write to the same index receives the new descriptor through a bypass path, with no stall. The descriptor holds register numbers and not values. A branch therefore always compares the register contents present at its own decode, however long ago the descriptor was written. The branch opcode chooses register-register or register-constant form, so one descriptor can serve both forms.

Top module: `cspec_branch_unit`

## Requirements
- R1: After reset every descriptor is zero and ex_valid and ex_taken are 0. A branch on any index then reads register 0 on both address outputs.
- R2: While a branch is in decode, gp_raddr_a carries bits 15:12 of the selected descriptor and gp_raddr_b carries bits 3:0, in the same cycle.
- R3: A spec write with spec_we=1 stores spec_data at spec_idx. Any later branch on that index uses it until it is overwritten.
- R4: A branch presented in the cycle directly after a spec write to the same index uses the newly written descriptor.
- R5: With br_imm_form=0, the second operand is the general-purpose value read at bits 3:0 of the descriptor.
- R6: With br_imm_form=1, the second operand is bits 11:4 of the descriptor, sign-extended to the datapath width. The first operand is still the register named by bits 15:12.
- R7: While stall is 1, ex_valid and ex_taken keep the values they had before the stall.
- R8: The operator br_op is encoded as 0 equal, 1 not-equal, 2 less-than, 3 less-or-equal, 4 greater-than and 5 greater-or-equal. Operands compare as signed two's-complement numbers. ex_taken reflects the result one clock edge after the branch is in decode.
- R9: Operator codes 6 and 7 never set ex_taken.
- R10: A branch compares the register contents present at its own decode, even when those registers changed after the descriptor was written.
- R11: When not stalled, ex_valid equals br_valid one edge earlier. ex_taken is 0 whenever ex_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_we | input | 1 | Spec-write instruction in decode |
| spec_idx | input | IDX_W (4) | Descriptor index to write |
| spec_data | input | 16 | Descriptor: [15:12] reg A, [11:4] constant, [3:0] reg B |
| br_valid | input | 1 | Compare-and-branch in decode |
| br_idx | input | IDX_W (4) | Descriptor index to read |
| br_imm_form | input | 1 | 1: register-constant form, 0: register-register form |
| br_op | input | 3 | Relational operator code |
| stall | input | 1 | Freeze the decode-to-execute latches |
| gp_raddr_a | output | 4 | General-purpose read address, first operand |
| gp_raddr_b | output | 4 | General-purpose read address, second operand |
| gp_rdata_a | input | DATA_W (32) | Read data for gp_raddr_a, same cycle |
| gp_rdata_b | input | DATA_W (32) | Read data for gp_raddr_b, same cycle |
| ex_valid | output | 1 | A branch occupies execute |
| ex_taken | output | 1 | Branch in execute resolves taken |

## Verification
The assertions assume that the general-purpose read data follows the two read addresses within the same cycle. They also assume that an instruction held in decode by a stall is presented again unchanged. The bench models the register file as a combinational array indexed by the unit's own address outputs, and it changes register contents only between cycles, never within a decode cycle. Indices are drawn mostly from a narrow range so that back-to-back write-then-read pairs on the same index occur often. Register values are biased toward small and byte-range numbers so that equality and constant matches happen regularly.

// File: rtl/cspec_pkg.sv
package cspec_pkg;

    localparam int REG_IDX_W = 4;
    localparam int KONST_W   = 8;
    localparam int SPEC_W    = 2 * REG_IDX_W + KONST_W;

    typedef enum logic [2:0] {
        REL_EQ  = 3'd0,
        REL_NE  = 3'd1,
        REL_LT  = 3'd2,
        REL_LE  = 3'd3,
        REL_GT  = 3'd4,
        REL_GE  = 3'd5,
        REL_NV6 = 3'd6,
        REL_NV7 = 3'd7
    } rel_op_e;

    // field order is decoded by the register-read path
    typedef struct packed {
        logic [REG_IDX_W-1:0] reg_a;
        logic [KONST_W-1:0]   konst;
        logic [REG_IDX_W-1:0] reg_b;
    } spec_t;

endpackage

// File: rtl/cspec_file.sv
module cspec_file
    import cspec_pkg::*;
#(
    parameter int NUM_SPECS = 16,
    localparam int IDX_W    = $clog2(NUM_SPECS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  spec_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output spec_t            rd_data
);

    typedef struct packed {
        logic                  pend_vld;
        logic [IDX_W-1:0]      pend_idx;
        spec_t                 pend_data;
        spec_t [NUM_SPECS-1:0] mem;
    } file_state_t;

    file_state_t st_d, st_q;
    logic [NUM_SPECS-1:0] commit_sel;

    // one commit strobe per entry
    for (genvar g = 0; g < NUM_SPECS; g++) begin : g_commit
        assign commit_sel[g] = st_q.pend_vld && (st_q.pend_idx == IDX_W'(g));
    end

    always_comb begin
        st_d           = st_q;
        st_d.pend_vld  = wr_en;
        st_d.pend_idx  = wr_idx;
        st_d.pend_data = wr_data;
        for (int i = 0; i < NUM_SPECS; i++) begin
            if (commit_sel[i]) begin
                st_d.mem[i] = st_q.pend_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // newest spec wins over the stored copy
    always_comb begin
        if (st_q.pend_vld && (st_q.pend_idx == rd_idx)) begin
            rd_data = st_q.pend_data;
        end else begin
            rd_data = st_q.mem[rd_idx];
        end
    end

    assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend_vld |=> (st_q.mem[$past(st_q.pend_idx)] == $past(st_q.pend_data)));

    assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_idx != $past(wr_idx)) || (rd_data == $past(wr_data))));

endmodule

// File: rtl/cspec_operand_sel.sv
module cspec_operand_sel
    import cspec_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int EXT_W = DATA_W - KONST_W
) (
    input  spec_t                entry,
    input  logic                 imm_form,
    input  logic [DATA_W-1:0]    gp_rdata_a,
    input  logic [DATA_W-1:0]    gp_rdata_b,
    output logic [REG_IDX_W-1:0] gp_raddr_a,
    output logic [REG_IDX_W-1:0] gp_raddr_b,
    output logic [DATA_W-1:0]    opnd_a,
    output logic [DATA_W-1:0]    opnd_b
);

    logic [DATA_W-1:0] konst_ext;

    always_comb begin
        gp_raddr_a = entry.reg_a;
        gp_raddr_b = entry.reg_b;
        konst_ext  = {{EXT_W{entry.konst[KONST_W-1]}}, entry.konst};
        opnd_a     = gp_rdata_a;
        opnd_b     = imm_form ? konst_ext : gp_rdata_b;
    end

endmodule

// File: rtl/cspec_compare.sv
module cspec_compare
    import cspec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  rel_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              hit
);

    logic is_eq, is_lt;

    always_comb begin
        is_eq = (a == b);
        is_lt = ($signed(a) < $signed(b));
        unique case (op)
            REL_EQ:  hit = is_eq;
            REL_NE:  hit = !is_eq;
            REL_LT:  hit = is_lt;
            REL_LE:  hit = is_lt || is_eq;
            REL_GT:  hit = !is_lt && !is_eq;
            REL_GE:  hit = !is_lt;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cspec_branch_unit.sv
module cspec_branch_unit
    import cspec_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_SPECS = 16,
    localparam int IDX_W    = $clog2(NUM_SPECS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spec_we,
    input  logic [IDX_W-1:0]     spec_idx,
    input  logic [SPEC_W-1:0]    spec_data,
    input  logic                 br_valid,
    input  logic [IDX_W-1:0]     br_idx,
    input  logic                 br_imm_form,
    input  logic [2:0]           br_op,
    input  logic                 stall,
    output logic [REG_IDX_W-1:0] gp_raddr_a,
    output logic [REG_IDX_W-1:0] gp_raddr_b,
    input  logic [DATA_W-1:0]    gp_rdata_a,
    input  logic [DATA_W-1:0]    gp_rdata_b,
    output logic                 ex_valid,
    output logic                 ex_taken
);

    typedef struct packed {
        logic              vld;
        rel_op_e           op;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } ex_state_t;

    ex_state_t ex_d, ex_q;
    spec_t wr_spec, rd_spec;
    logic [DATA_W-1:0] opnd_a, opnd_b;
    logic cmp_hit;

    assign wr_spec = spec_t'(spec_data);

    cspec_file #(.NUM_SPECS(NUM_SPECS)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (spec_we),
        .wr_idx  (spec_idx),
        .wr_data (wr_spec),
        .rd_idx  (br_idx),
        .rd_data (rd_spec)
    );

    cspec_operand_sel #(.DATA_W(DATA_W)) u_opsel (
        .entry      (rd_spec),
        .imm_form   (br_imm_form),
        .gp_rdata_a (gp_rdata_a),
        .gp_rdata_b (gp_rdata_b),
        .gp_raddr_a (gp_raddr_a),
        .gp_raddr_b (gp_raddr_b),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b)
    );

    always_comb begin
        ex_d = ex_q;
        if (!stall) begin
            ex_d.vld = br_valid;
            ex_d.op  = rel_op_e'(br_op);
            ex_d.a   = opnd_a;
            ex_d.b   = opnd_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q <= '0;
        end else begin
            ex_q <= ex_d;
        end
    end

    cspec_compare #(.DATA_W(DATA_W)) u_cmp (
        .op  (ex_q.op),
        .a   (ex_q.a),
        .b   (ex_q.b),
        .hit (cmp_hit)
    );

    assign ex_valid = ex_q.vld;
    assign ex_taken = ex_q.vld & cmp_hit;

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(ex_taken) && $stable(ex_valid)));

    assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (ex_valid == $past(br_valid)));

    assert_reserved_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_q.op == REL_NV6 || ex_q.op == REL_NV7) |-> !ex_taken);

    assert_gp_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spec_we ##1 (br_idx == $past(spec_idx))
        |-> (gp_raddr_a == $past(spec_data[15:12]) && gp_raddr_b == $past(spec_data[3:0])));

endmodule

// File: tb/cspec_branch_unit_tb_top.sv
module cspec_branch_unit_tb_top;

    localparam int CLK_HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        spec_we;
    logic [3:0]  spec_idx;
    logic [15:0] spec_data;
    logic        br_valid;
    logic [3:0]  br_idx;
    logic        br_imm_form;
    logic [2:0]  br_op;
    logic        stall;
    logic [3:0]  gp_raddr_a, gp_raddr_b;
    logic [31:0] gp_rdata_a, gp_rdata_b;
    logic        ex_valid, ex_taken;

    logic [31:0] gpr [16];
    logic [15:0] model [16];
    logic        exp_v, exp_t;
    int          n_checks = 0;
    int          n_fail   = 0;

    always #(CLK_HALF) clk = ~clk;

    assign gp_rdata_a = gpr[gp_raddr_a];
    assign gp_rdata_b = gpr[gp_raddr_b];

    cspec_branch_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .spec_we(spec_we), .spec_idx(spec_idx), .spec_data(spec_data),
        .br_valid(br_valid), .br_idx(br_idx), .br_imm_form(br_imm_form),
        .br_op(br_op), .stall(stall),
        .gp_raddr_a(gp_raddr_a), .gp_raddr_b(gp_raddr_b),
        .gp_rdata_a(gp_rdata_a), .gp_rdata_b(gp_rdata_b),
        .ex_valid(ex_valid), .ex_taken(ex_taken)
    );

    function automatic logic rel(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return $signed(a) <  $signed(b);
            3'd3: return $signed(a) <= $signed(b);
            3'd4: return $signed(a) >  $signed(b);
            3'd5: return $signed(a) >= $signed(b);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] pick_val(input int unsigned r);
        case (r % 3)
            0: return 32'(int'(r % 7) - 3);
            1: return 32'(int'((r >> 3) % 256) - 128);
            default: return $urandom;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one decode cycle; ex outputs checked mid-cycle after the edge
    task automatic step(input logic we, input logic [3:0] widx, input logic [15:0] wdata,
                        input logic bv, input logic [3:0] bidx, input logic imm,
                        input logic [2:0] op, input logic stl, input string tag);
        logic [15:0] ent;
        logic [31:0] a, b;
        @(negedge clk);
        spec_we = we; spec_idx = widx; spec_data = wdata;
        br_valid = bv; br_idx = bidx; br_imm_form = imm; br_op = op; stall = stl;
        ent = model[bidx];
        #1;
        if (bv && !stl) begin
            chk(gp_raddr_a == ent[15:12], {tag, " R2 raddr_a"}, 32'(gp_raddr_a), 32'(ent[15:12]));
            chk(gp_raddr_b == ent[3:0],   {tag, " R2 raddr_b"}, 32'(gp_raddr_b), 32'(ent[3:0]));
        end
        a = gpr[ent[15:12]];
        b = imm ? {{24{ent[11]}}, ent[11:4]} : gpr[ent[3:0]];
        @(posedge clk);
        if (we) model[widx] = wdata;
        if (!stl) begin
            exp_v = bv;
            exp_t = bv & rel(op, a, b);
        end
        #5;
        chk(ex_valid == exp_v, {tag, " R11 ex_valid"}, 32'(ex_valid), 32'(exp_v));
        chk(ex_taken == exp_t, {tag, " R8 ex_taken"},  32'(ex_taken), 32'(exp_t));
    endtask

    initial begin
        #(2 * CLK_HALF * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin
            gpr[i] = 32'(i * 3);
            model[i] = '0;
        end
        exp_v = 0; exp_t = 0;
        rst_n = 0; spec_we = 0; spec_idx = 0; spec_data = 0;
        br_valid = 0; br_idx = 0; br_imm_form = 0; br_op = 0; stall = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(ex_valid == 0, "R1 reset ex_valid", 32'(ex_valid), 0);
        chk(ex_taken == 0, "R1 reset ex_taken", 32'(ex_taken), 0);

        // R1: cleared descriptor compares r0 with r0
        step(0, 0, 0, 1, 4'd9, 0, 3'd0, 0, "R1");
        // R4: write then branch on the next cycle
        gpr[1] = 32'(-4); gpr[5] = 32'd7;
        step(1, 4'd3, 16'h12A5, 0, 0, 0, 3'd0, 0, "R4 write");
        step(0, 0, 0, 1, 4'd3, 0, 3'd2, 0, "R4");
        // R3: later read of the stored entry
        step(0, 0, 0, 0, 0, 0, 3'd0, 0, "R3 idle");
        step(0, 0, 0, 1, 4'd3, 0, 3'd3, 0, "R3");
        // R10: register changed after spec write
        gpr[1] = 32'd100;
        step(0, 0, 0, 1, 4'd3, 0, 3'd2, 0, "R10");
        // R6: negative constant
        gpr[2] = 32'(-16); gpr[0] = 32'd0;
        step(1, 4'd7, {4'd2, 8'hF0, 4'd0}, 0, 0, 0, 3'd0, 0, "R6 write");
        step(0, 0, 0, 1, 4'd7, 1, 3'd0, 0, "R6");
        gpr[2] = 32'(-15);
        step(0, 0, 0, 1, 4'd7, 1, 3'd4, 0, "R6 gt");
        // R5: same descriptor in register form
        step(0, 0, 0, 1, 4'd7, 0, 3'd2, 0, "R5");
        // R9: reserved codes on equal operands
        step(0, 0, 0, 1, 4'd9, 0, 3'd6, 0, "R9");
        step(0, 0, 0, 1, 4'd9, 0, 3'd7, 0, "R9");
        // R7: taken branch held through stall
        step(0, 0, 0, 1, 4'd9, 0, 3'd5, 0, "R7 setup");
        step(0, 0, 0, 0, 0, 0, 3'd1, 1, "R7");
        step(1, 4'd9, 16'h3001, 1, 4'd9, 0, 3'd1, 1, "R7");
        // R11: bubble clears valid
        step(0, 0, 0, 0, 0, 0, 3'd0, 0, "R11");

        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom;
            if (r % 4 == 0) gpr[$urandom % 16] = pick_val($urandom);
            step((r >> 2) % 2 == 1, 4'((r >> 3) % 4), 16'($urandom),
                 (r >> 5) % 4 != 0, 4'((r >> 7) % 4), (r >> 9) % 2 == 1,
                 3'((r >> 10) % 8), (r >> 13) % 8 == 0, "R8 rand");
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule